// File: doc/BRIEF.md
# Set Associative Data Cache with Split Dirty Tracking

A configurable set associative data cache that sits between a word-wide CPU request port and a word-wide memory port. Each 32-bit byte address is divided into a tag, a set index and a word-within-line offset. The two lowest bits select a byte, and the cache ignores them. A lookup compares the tag against every way of the indexed set. A hit completes without memory traffic. A miss fills the whole line from memory one word at a time, in ascending word order.

Each set has its own round-robin pointer, which chooses the way to replace. Every line holds a valid flag and two dirty flags, one for its lower half and one for its upper half. In write-back operation, an evicted line writes back only the halves that were modified.

A mode input selects write-through operation instead. In that mode every write goes straight to memory, the dirty flags are never set, and a write miss leaves the cache contents untouched. The mode may only be changed while the cache holds no dirty lines.

Top module: `sa_cache`

## Requirements
- R1: After reset, and whenever the cache is idle, `req_ready_o` is high while `resp_valid_o` and `mem_req_o` are low. An accepted request drops `req_ready_o` on the next cycle.
- R2: A read that hits returns the stored word with `resp_valid_o` and makes no memory access.
- R3: A read miss fetches exactly LINE_BYTES/4 words of the line from memory and then returns the requested word.
- R4: Each set replaces its ways in round-robin order, starting from way 0, and advances its pointer modulo WAYS after each fill. A fill in one set leaves the pointers of the other sets unchanged.
- R5: In write-back mode (`write_through_i` = 0), a write hit updates the line and makes no memory access.
- R6: On a write-back eviction, each half of the victim line that holds a modified word is written to memory, LINE_BYTES/8 words per half. A half that was not modified causes no memory write. A clean victim causes none at all.
- R7: A word written in write-back mode and then evicted is returned with its written value when it is read again.
- R8: In write-back mode, a write miss allocates the line (one full fill with no memory write), and a later read of that word hits.
- R9: In write-through mode (`write_through_i` = 1), every write makes exactly one memory write of the addressed word. A write miss makes no memory read, no line ever becomes dirty, and a later eviction of such a line writes nothing back.
- R10: Address bits [1:0] are ignored. Bits [OFF-1:2] pick the word within the line, where OFF = log2(LINE_BYTES). The next log2(SETS) bits pick the set, and the remaining high bits form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| write_through_i | input | 1 | 1 selects write-through, 0 selects write-back |
| req_valid_i | input | 1 | CPU request valid |
| req_ready_o | output | 1 | Cache idle and able to accept a request |
| req_we_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | One-cycle completion pulse |
| resp_rdata_o | output | 32 | Read data, valid with `resp_valid_o` on reads |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory completes the current access |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |

## Verification
The bench targets the three eviction cases: one dirty half, both dirty halves and a clean victim. It counts the memory writes for each. A design that wrote whole lines would show four writes where two are expected, and one that skipped write-back would return stale data on re-read.

The bench interleaves fills so that the round-robin pointer of one set must evict the older line and keep the newer one. It also fills a different set in between, to expose a pointer shared across sets.

In write-through mode, the bench checks that a write miss performs a single write and no fill. It also checks that a line written in that mode is later evicted silently, which catches a design that sets dirty flags regardless of mode.

Finally, a read with a non-zero byte offset must hit the same word. This catches a design that slices the address fields one bit off.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_WT
  } cache_state_e;

  // bit 0 valid, bit 1 lower-half dirty, bit 2 upper-half dirty
  typedef struct packed {
    logic dirty_hi;
    logic dirty_lo;
    logic valid;
  } line_stat_t;

endpackage

// File: rtl/sa_cache_tags.sv
module sa_cache_tags
  import sa_cache_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 4,
  parameter int TAG_W = 26,
  parameter int SET_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] victim_way_o,
  output logic [TAG_W-1:0] victim_tag_o,
  output line_stat_t       victim_stat_o,
  input  logic             fill_done_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             mark_i,
  input  logic [WAY_W-1:0] mark_way_i,
  input  logic             mark_half_i,
  output logic             any_dirty_o
);

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  line_stat_t       stat_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q   [SETS];

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (stat_q[set_i][w].valid && (tag_q[set_i][w] == tag_i)) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end

  assign victim_way_o  = rr_q[set_i];
  assign victim_tag_o  = tag_q[set_i][rr_q[set_i]];
  assign victim_stat_o = stat_q[set_i][rr_q[set_i]];

  always_comb begin
    any_dirty_o = 1'b0;
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (stat_q[s][w].dirty_lo || stat_q[s][w].dirty_hi) any_dirty_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_done_i) tag_q[set_i][fill_way_i] <= tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) stat_q[s][w] <= '0;
      end
    end else begin
      if (fill_done_i) begin
        stat_q[set_i][fill_way_i] <= '{dirty_hi: 1'b0, dirty_lo: 1'b0, valid: 1'b1};
        rr_q[set_i] <= (rr_q[set_i] == WAY_W'(WAYS - 1)) ? '0 : rr_q[set_i] + WAY_W'(1);
      end
      if (mark_i) begin
        if (mark_half_i) stat_q[set_i][mark_way_i].dirty_hi <= 1'b1;
        else             stat_q[set_i][mark_way_i].dirty_lo <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sa_cache_data.sv
module sa_cache_data #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [31:0]      rdata_o
);

  logic [31:0] mem_q [2**IDX_W];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int WAYS       = 2,
  parameter int SETS       = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        write_through_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_we_i,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        resp_valid_o,
  output logic [31:0] resp_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i
);

  localparam int WORDS  = LINE_BYTES / 4;
  localparam int HALF   = WORDS / 2;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W  = 32 - OFF_W - SET_W;
  localparam int IDX_W  = SET_W + WAY_W + WOFF_W;

  cache_state_e state_q, state_d;
  logic [31:0]       addr_q, wdata_q;
  logic              we_q;
  logic [WOFF_W-1:0] cnt_q, cnt_d;
  logic [WAY_W-1:0]  way_q, way_d;

  logic [WOFF_W-1:0] word_w;
  logic [SET_W-1:0]  set_w;
  logic [TAG_W-1:0]  tag_w;
  assign word_w = addr_q[OFF_W-1:2];
  assign set_w  = addr_q[OFF_W+SET_W-1:OFF_W];
  assign tag_w  = addr_q[31:OFF_W+SET_W];

  logic             hit;
  logic [WAY_W-1:0] hit_way, victim_way;
  logic [TAG_W-1:0] victim_tag;
  line_stat_t       victim_stat;
  logic             fill_done, mark, any_dirty;

  logic             d_we;
  logic [IDX_W-1:0] d_waddr, d_raddr;
  logic [31:0]      d_wdata, d_rdata;

  sa_cache_tags #(
    .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_w),
    .tag_i        (tag_w),
    .hit_o        (hit),
    .hit_way_o    (hit_way),
    .victim_way_o (victim_way),
    .victim_tag_o (victim_tag),
    .victim_stat_o(victim_stat),
    .fill_done_i  (fill_done),
    .fill_way_i   (way_q),
    .mark_i       (mark),
    .mark_way_i   (hit_way),
    .mark_half_i  (word_w[WOFF_W-1]),
    .any_dirty_o  (any_dirty)
  );

  sa_cache_data #(.IDX_W(IDX_W)) u_data (
    .clk_i  (clk_i),
    .we_i   (d_we),
    .waddr_i(d_waddr),
    .wdata_i(d_wdata),
    .raddr_i(d_raddr),
    .rdata_o(d_rdata)
  );

  logic half_dirty, evict_last;
  assign half_dirty = cnt_q[WOFF_W-1] ? victim_stat.dirty_hi : victim_stat.dirty_lo;
  // clean upper half, or last word: eviction ends here
  assign evict_last = (cnt_q == WOFF_W'(WORDS - 1)) || (!half_dirty && cnt_q[WOFF_W-1]);

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_rdata_o = d_rdata;

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    way_d        = way_q;
    resp_valid_o = 1'b0;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = '0;
    mem_wdata_o  = '0;
    d_we         = 1'b0;
    d_waddr      = {set_w, hit_way, word_w};
    d_wdata      = wdata_q;
    d_raddr      = {set_w, hit_way, word_w};
    fill_done    = 1'b0;
    mark         = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (hit) begin
          if (!we_q) begin
            resp_valid_o = 1'b1;
            state_d      = ST_IDLE;
          end else begin
            d_we = 1'b1;
            if (write_through_i) begin
              state_d = ST_WT;
            end else begin
              mark         = 1'b1;
              resp_valid_o = 1'b1;
              state_d      = ST_IDLE;
            end
          end
        end else if (we_q && write_through_i) begin
          state_d = ST_WT;
        end else begin
          way_d   = victim_way;
          cnt_d   = '0;
          state_d = (!write_through_i && victim_stat.valid &&
                     (victim_stat.dirty_lo || victim_stat.dirty_hi)) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        d_raddr = {set_w, way_q, cnt_q};
        if (half_dirty) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = {victim_tag, set_w, cnt_q, 2'b00};
          mem_wdata_o = d_rdata;
        end
        if (!half_dirty || mem_ack_i) begin
          if (evict_last) begin
            cnt_d   = '0;
            state_d = ST_FILL;
          end else if (!half_dirty) begin
            cnt_d = WOFF_W'(HALF);
          end else begin
            cnt_d = cnt_q + WOFF_W'(1);
          end
        end
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {tag_w, set_w, cnt_q, 2'b00};
        if (mem_ack_i) begin
          d_we    = 1'b1;
          d_waddr = {set_w, way_q, cnt_q};
          d_wdata = mem_rdata_i;
          if (cnt_q == WOFF_W'(WORDS - 1)) begin
            fill_done = 1'b1;
            state_d   = ST_LOOKUP;
          end else begin
            cnt_d = cnt_q + WOFF_W'(1);
          end
        end
      end
      ST_WT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {addr_q[31:2], 2'b00};
        mem_wdata_o = wdata_q;
        if (mem_ack_i) begin
          resp_valid_o = 1'b1;
          state_d      = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      way_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      way_q   <= way_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        we_q    <= req_we_i;
      end
    end
  end

endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        write_through_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        resp_valid_o,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        any_dirty_i
);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!resp_valid_o && !mem_req_o));  // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);  // R1
  AST_READ_HIT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !mem_we_o) |-> !mem_req_o);  // R2
  AST_WB_RESP_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!write_through_i && resp_valid_o) |-> !mem_req_o);  // R5
  AST_WT_NEVER_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_through_i |-> !any_dirty_i);  // R9

endmodule

bind sa_cache sa_cache_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .write_through_i(write_through_i),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .resp_valid_o   (resp_valid_o),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .any_dirty_i    (any_dirty)
);

// File: tb/sa_cache_tb.sv
module sa_cache_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wt = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #2 clk = ~clk;

  sa_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n), .write_through_i(wt),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int checks = 0, errors = 0, rd_cnt = 0, wr_cnt = 0, cycles = 0;
  logic [31:0] mem_q [logic [31:0]];
  logic [31:0] ref_q [logic [31:0]];
  logic [31:0] exp_q [$];
  bit          isrd_q [$];
  string       req_q [$];

  function automatic logic [31:0] seed(logic [31:0] a);
    return a ^ 32'hC3A5_0F1E;
  endfunction

  // LINE_BYTES=16, SETS=4: word [3:2], set [5:4], tag [31:6]
  function automatic logic [31:0] mk(int t, int s, int w);
    return (32'(t) << 6) | (32'(s) << 4) | (32'(w) << 2);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  // memory model: always ready, data presented away from the edge
  assign mem_ack = mem_req;
  always @(negedge clk) mem_rdata = mem_q.exists(mem_addr) ? mem_q[mem_addr] : seed(mem_addr);
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) begin
        mem_q[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        rd_cnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R1 unexpected response actual 1 expected 0");
      end else begin
        logic [31:0] e;
        bit          rd;
        string       r;
        e  = exp_q.pop_front();
        rd = isrd_q.pop_front();
        r  = req_q.pop_front();
        if (rd) chk({r, " data"}, resp_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected <100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(bit we, logic [31:0] a, logic [31:0] d, int erd, int ewr, string r);
    int rd0, wr0;
    logic [31:0] wa;
    wa = {a[31:2], 2'b00};
    @(negedge clk);
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    if (we) ref_q[wa] = d;
    exp_q.push_back(we ? 32'h0 : (ref_q.exists(wa) ? ref_q[wa] : seed(wa)));
    isrd_q.push_back(!we);
    req_q.push_back(r);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    if (erd >= 0) chk({r, " mem reads"}, 32'(rd_cnt - rd0), 32'(erd));
    if (ewr >= 0) chk({r, " mem writes"}, 32'(wr_cnt - wr0), 32'(ewr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 resp", {31'd0, resp_valid}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    // write-through phase
    access(1, mk(1, 0, 1), 32'h1111_0001, 0, 1, "R9 wt write miss");
    access(0, mk(1, 0, 1), 0, 4, 0, "R3 read miss fill");
    access(0, mk(1, 0, 1), 0, 0, 0, "R2 read hit");
    access(1, mk(1, 0, 2), 32'h1111_0002, 0, 1, "R9 wt write hit");
    access(0, mk(1, 0, 2) | 32'd3, 0, 0, 0, "R10 byte offset");

    @(negedge clk);
    wt = 1'b0;

    // write-back phase, set 1
    access(1, mk(2, 1, 0), 32'hA000_0000, 4, 0, "R8 wb write miss");
    access(1, mk(2, 1, 1), 32'hA000_0001, 0, 0, "R5 wb write hit");
    access(0, mk(2, 1, 0), 0, 0, 0, "R8 read after alloc");
    access(0, mk(3, 1, 3), 0, 4, 0, "R3 fill second way");
    access(0, mk(4, 1, 0), 0, 4, 2, "R6 lower half dirty");
    access(0, mk(3, 1, 3), 0, 0, 0, "R4 newer line kept");
    access(0, mk(2, 1, 1), 0, 4, 0, "R7 reload after evict");
    access(1, mk(2, 1, 2), 32'hA000_0002, 0, 0, "R5 hit upper a");
    access(1, mk(2, 1, 3), 32'hA000_0003, 0, 0, "R5 hit upper b");
    access(1, mk(2, 1, 0), 32'hA000_0010, 0, 0, "R5 hit lower");
    access(0, mk(5, 2, 0), 0, 4, 0, "R4 other set fill");
    access(0, mk(6, 1, 0), 0, 4, 0, "R4 pointer per set");
    access(0, mk(7, 1, 0), 0, 4, 4, "R6 both halves dirty");
    access(0, mk(2, 1, 0), 0, 4, 0, "R7 reload word0");
    for (int w = 1; w < 4; w++) access(0, mk(2, 1, w), 0, 0, 0, "R7 reload hit");

    // set 0 still holds the line written in write-through mode
    access(0, mk(8, 0, 0), 0, 4, 0, "R4 fill empty way");
    access(0, mk(9, 0, 0), 0, 4, 0, "R9 wt line evicts clean");
    chk("R7 memory holds upper word", mem_q.exists(mk(2, 1, 3)) ? mem_q[mk(2, 1, 3)] : 32'hx,
        32'hA000_0003);

    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule